// File: doc/BRIEF.md
# Priority Interrupt Arbiter

The block holds a row of interrupt source nodes and a single control unit that chooses among them. Each node keeps a request flag, an enable bit and an 8-bit priority number. Hardware raises a node's flag with a one-cycle pulse. Software updates a node with a single register write that carries the enable bit, the priority number and two one-shot command bits, one to set the flag and one to clear it. The command bits are acted on in the cycle of the write and are not kept.

The control unit runs a fixed-length arbitration round over the enabled, flagged nodes that have a non-zero priority. The largest number wins the round and is published as the pending priority. The block asks the CPU for service when interrupts are globally enabled and the pending priority is above the CPU's current level. It also presents a vector address, formed by placing the pending priority 5 bits up and merging it with a base address.

When the CPU accepts the request, the winner's flag is dropped, the pending priority goes to zero, the CPU level takes the accepted number, the global enable is cleared and a new round is started. A return-from-exception pulse sets the global enable again.

Top module: `irq_arb_top`

## Requirements
- R1: After reset all flags, enables and priorities are 0, the pending priority is 0, the CPU level is 0, the global enable is 1, and busy, request and configuration error are all 0.
- R2: A hardware pulse sets the node's flag. A software write with set=1 and clr=0 sets the flag, and one with clr=1 and set=0 clears it. A write with both command bits at 1, or both at 0, leaves the flag as it was.
- R3: When a software write and a hardware pulse reach the same node in the same cycle, the outcome of the write alone decides the flag, and the hardware pulse is lost.
- R4: A node with its enable bit at 0 still latches and shows its flag, but it never becomes the pending priority.
- R5: The pending priority is the largest priority among the flagged, enabled nodes. A priority of 0 is never pending. When two nodes tie, the one with the lower index wins.
- R6: A round keeps busy high for exactly 2 cycles. When a pulse is sampled at clock edge E0, the request can rise after edge E3. A new request sampled during a round does not change that round, and a further round follows it.
- R7: Acceptance is an ack pulse while the request is high. It clears the winner's flag and zeroes the pending priority at the same edge, then re-arbitrates. An ack while the request is low changes nothing.
- R8: The vector address equals (pending priority << 5) OR the base input with bit 0 forced to 0.
- R9: The request is high only when the global enable is 1, no round is running or due, and the pending priority is strictly greater than the CPU level.
- R10: On acceptance the global enable becomes 0 and the CPU level takes the accepted priority. A return pulse sets the global enable to 1. A CPU level write loads the level. If an acceptance happens in the same cycle as a return pulse or a level write, the acceptance takes effect.
- R11: The configuration error output is high exactly when two or more enabled nodes hold the same non-zero priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | NUM_NODES | Hardware request pulses, one per node |
| sw_wr_i | input | 1 | Software node write strobe |
| sw_node_i | input | IDX_W | Node selected by the write |
| sw_set_i | input | 1 | Set-flag command bit |
| sw_clr_i | input | 1 | Clear-flag command bit |
| sw_en_i | input | 1 | Enable bit written to the node |
| sw_prio_i | input | PRIO_W | Priority written to the node |
| ack_i | input | 1 | CPU acceptance pulse |
| rfe_i | input | 1 | Return-from-exception pulse |
| cpu_lvl_wr_i | input | 1 | CPU level load strobe |
| cpu_lvl_i | input | PRIO_W | CPU level value |
| vec_base_i | input | ADDR_W | Vector table base address |
| flags_o | output | NUM_NODES | Request flags of all nodes |
| busy_o | output | 1 | Arbitration round in progress |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| pend_prio_o | output | PRIO_W | Pending priority |
| vec_addr_o | output | ADDR_W | Vector entry address |
| gie_o | output | 1 | Global interrupt enable |
| cpu_prio_o | output | PRIO_W | Current CPU priority level |
| cfg_err_o | output | 1 | Duplicate enabled priority detected |

## Verification
The assertions assume that ack_i and rfe_i are single-cycle pulses. They also assume that the node index on a software write names a node that exists, and that vec_base_i stays steady whenever the vector is read. The stimulus drives every input on the falling edge and keeps each strobe high for exactly one cycle. It writes node indices only below the node count. Between events it leaves enough idle cycles for any round already started to finish.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_RUN  = 1'b1
  } arb_state_e;
endpackage

// File: rtl/irq_node.sv
module irq_node #(
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              hw_set_i,
  input  logic              hw_clr_i,
  output logic              flag_o,
  output logic              en_o,
  output logic [PRIO_W-1:0] prio_o
);
  logic              flag_q;
  logic              en_q;
  logic [PRIO_W-1:0] prio_q;

  // software write owns the flag in its cycle; hw events are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      prio_q <= '0;
    end else if (wr_i) begin
      en_q   <= en_i;
      prio_q <= prio_i;
      if (set_i && !clr_i)      flag_q <= 1'b1;
      else if (clr_i && !set_i) flag_q <= 1'b0;
    end else if (hw_set_i) begin
      flag_q <= 1'b1;
    end else if (hw_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign prio_o = prio_q;

  // R2
  sw_cmd_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && set_i && clr_i) |=> (flag_q == $past(flag_q)));

  // R3
  sw_over_hw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !set_i && !clr_i && hw_set_i) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/irq_maxfind.sv
module irq_maxfind #(
  parameter int N      = 4,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  input  logic [N-1:0]             cand_i,
  input  logic [N-1:0]             en_i,
  output logic [PRIO_W-1:0]        best_prio_o,
  output logic [IDX_W-1:0]         best_idx_o,
  output logic                     dup_o
);
  // strict compare: ties keep the lower index, zero never beats the start value
  always_comb begin
    best_prio_o = '0;
    best_idx_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (prio_i[i] > best_prio_o)) begin
        best_prio_o = prio_i[i];
        best_idx_o  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    dup_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (en_i[i] && en_i[j] && (prio_i[i] != '0) && (prio_i[i] == prio_i[j]))
          dup_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_arb_pkg::*;
#(
  parameter int N       = 4,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 2,
  parameter int ARB_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [N-1:0]      cand_i,
  input  logic [PRIO_W-1:0] best_prio_i,
  input  logic [IDX_W-1:0]  best_idx_i,
  input  logic              ack_i,
  input  logic              rfe_i,
  input  logic              lvl_wr_i,
  input  logic [PRIO_W-1:0] lvl_i,
  output logic [N-1:0]      snap_o,
  output logic              busy_o,
  output logic [PRIO_W-1:0] pend_prio_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic              ack_acc_o,
  output logic              irq_req_o,
  output logic              gie_o,
  output logic [PRIO_W-1:0] cpu_prio_o
);
  localparam int CNT_W = (ARB_CYC > 1) ? $clog2(ARB_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ARB_CYC - 1);

  arb_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rearm_q;
  logic [N-1:0]      snap_q;
  logic [PRIO_W-1:0] pend_q;
  logic [IDX_W-1:0]  win_q;
  logic              gie_q;
  logic [PRIO_W-1:0] cpu_q;
  logic              start;

  assign start     = (state_q == ARB_IDLE) && rearm_q;
  assign irq_req_o = gie_q && (state_q == ARB_IDLE) && !rearm_q && (pend_q > cpu_q);
  assign ack_acc_o = ack_i && irq_req_o;

  // events during a round re-arm and are served by the next round
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rearm_q <= 1'b0;
    end else if (evt_i || ack_acc_o) begin
      rearm_q <= 1'b1;
    end else if (start) begin
      rearm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      cnt_q   <= '0;
      snap_q  <= '0;
      pend_q  <= '0;
      win_q   <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (ack_acc_o) pend_q <= '0;
          if (start) begin
            state_q <= ARB_RUN;
            cnt_q   <= '0;
            snap_q  <= cand_i;
          end
        end
        default: begin
          if (cnt_q == CNT_LAST) begin
            state_q <= ARB_IDLE;
            pend_q  <= best_prio_i;
            win_q   <= best_idx_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b1;
      cpu_q <= '0;
    end else if (ack_acc_o) begin
      gie_q <= 1'b0;
      cpu_q <= pend_q;
    end else begin
      if (rfe_i)    gie_q <= 1'b1;
      if (lvl_wr_i) cpu_q <= lvl_i;
    end
  end

  assign snap_o      = snap_q;
  assign busy_o      = (state_q == ARB_RUN);
  assign pend_prio_o = pend_q;
  assign win_idx_o   = win_q;
  assign gie_o       = gie_q;
  assign cpu_prio_o  = cpu_q;

  // R6
  arb_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARB_RUN && cnt_q != CNT_LAST) |=> (state_q == ARB_RUN));

  // R7
  ack_clears_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_acc_o |=> (pend_q == '0 && rearm_q));

  // R10
  accept_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_acc_o |=> (!gie_q && cpu_q == $past(pend_q)));

  // R10
  rfe_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i && !ack_acc_o) |=> gie_q);
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top #(
  parameter  int NUM_NODES = 4,
  parameter  int PRIO_W    = 8,
  parameter  int ADDR_W    = 32,
  parameter  int VEC_SHIFT = 5,
  parameter  int ARB_CYC   = 2,
  localparam int IDX_W     = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_NODES-1:0] hw_req_i,
  input  logic                 sw_wr_i,
  input  logic [IDX_W-1:0]     sw_node_i,
  input  logic                 sw_set_i,
  input  logic                 sw_clr_i,
  input  logic                 sw_en_i,
  input  logic [PRIO_W-1:0]    sw_prio_i,
  input  logic                 ack_i,
  input  logic                 rfe_i,
  input  logic                 cpu_lvl_wr_i,
  input  logic [PRIO_W-1:0]    cpu_lvl_i,
  input  logic [ADDR_W-1:0]    vec_base_i,
  output logic [NUM_NODES-1:0] flags_o,
  output logic                 busy_o,
  output logic                 irq_req_o,
  output logic [PRIO_W-1:0]    pend_prio_o,
  output logic [ADDR_W-1:0]    vec_addr_o,
  output logic                 gie_o,
  output logic [PRIO_W-1:0]    cpu_prio_o,
  output logic                 cfg_err_o
);
  logic [NUM_NODES-1:0]             flag;
  logic [NUM_NODES-1:0]             en;
  logic [NUM_NODES-1:0][PRIO_W-1:0] prio;
  logic [NUM_NODES-1:0]             cand;
  logic [NUM_NODES-1:0]             snap;
  logic [PRIO_W-1:0]                best_prio;
  logic [IDX_W-1:0]                 best_idx;
  logic [IDX_W-1:0]                 win_idx;
  logic                             ack_acc;
  logic                             evt;

  for (genvar g = 0; g < NUM_NODES; g++) begin : g_node
    logic node_wr;
    logic node_clr;
    assign node_wr  = sw_wr_i && (sw_node_i == IDX_W'(g));
    assign node_clr = ack_acc && (win_idx == IDX_W'(g));

    irq_node #(.PRIO_W(PRIO_W)) u_node (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (node_wr),
      .set_i    (sw_set_i),
      .clr_i    (sw_clr_i),
      .en_i     (sw_en_i),
      .prio_i   (sw_prio_i),
      .hw_set_i (hw_req_i[g]),
      .hw_clr_i (node_clr),
      .flag_o   (flag[g]),
      .en_o     (en[g]),
      .prio_o   (prio[g])
    );

    assign cand[g] = flag[g] && en[g] && (prio[g] != '0);
  end

  assign evt = (|hw_req_i) || sw_wr_i;

  irq_maxfind #(.N(NUM_NODES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_max (
    .prio_i      (prio),
    .cand_i      (snap),
    .en_i        (en),
    .best_prio_o (best_prio),
    .best_idx_o  (best_idx),
    .dup_o       (cfg_err_o)
  );

  irq_ctrl #(.N(NUM_NODES), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .ARB_CYC(ARB_CYC)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .cand_i      (cand),
    .best_prio_i (best_prio),
    .best_idx_i  (best_idx),
    .ack_i       (ack_i),
    .rfe_i       (rfe_i),
    .lvl_wr_i    (cpu_lvl_wr_i),
    .lvl_i       (cpu_lvl_i),
    .snap_o      (snap),
    .busy_o      (busy_o),
    .pend_prio_o (pend_prio_o),
    .win_idx_o   (win_idx),
    .ack_acc_o   (ack_acc),
    .irq_req_o   (irq_req_o),
    .gie_o       (gie_o),
    .cpu_prio_o  (cpu_prio_o)
  );

  assign flags_o    = flag;
  assign vec_addr_o = (ADDR_W'(pend_prio_o) << VEC_SHIFT) | (vec_base_i & ~ADDR_W'(1));

  // R5
  no_zero_service_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (pend_prio_o != '0));

  // R9
  req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (gie_o && !busy_o && pend_prio_o > cpu_prio_o));
endmodule

// File: tb/irq_arb_top_tb.sv
module irq_arb_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hw_req = '0;
  logic        sw_wr = 1'b0;
  logic [1:0]  sw_node = '0;
  logic        sw_set = 1'b0;
  logic        sw_clr = 1'b0;
  logic        sw_en = 1'b0;
  logic [7:0]  sw_prio = '0;
  logic        ack = 1'b0;
  logic        rfe = 1'b0;
  logic        lvl_wr = 1'b0;
  logic [7:0]  lvl = '0;
  logic [31:0] vec_base = '0;
  logic [3:0]  flags;
  logic        busy, irq_req, gie, cfg_err;
  logic [7:0]  pend_prio, cpu_prio;
  logic [31:0] vec_addr;

  int total = 0;
  int bad = 0;

  irq_arb_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .sw_wr_i(sw_wr),
    .sw_node_i(sw_node), .sw_set_i(sw_set), .sw_clr_i(sw_clr), .sw_en_i(sw_en),
    .sw_prio_i(sw_prio), .ack_i(ack), .rfe_i(rfe), .cpu_lvl_wr_i(lvl_wr),
    .cpu_lvl_i(lvl), .vec_base_i(vec_base), .flags_o(flags), .busy_o(busy),
    .irq_req_o(irq_req), .pend_prio_o(pend_prio), .vec_addr_o(vec_addr),
    .gie_o(gie), .cpu_prio_o(cpu_prio), .cfg_err_o(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic sw_write(input int node, input bit s, input bit c, input bit e, input int p);
    sw_wr = 1'b1; sw_node = 2'(node); sw_set = s; sw_clr = c; sw_en = e; sw_prio = 8'(p);
    tick();
    sw_wr = 1'b0; sw_set = 1'b0; sw_clr = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) sw_write(i, 1'b0, 1'b1, 1'b0, 0);
    tick(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk(flags == 4'h0, "R1 flags", flags, 0);
    chk(pend_prio == 8'h0 && cpu_prio == 8'h0, "R1 prio", {pend_prio, cpu_prio}, 0);
    chk(gie == 1'b1, "R1 gie", gie, 1);
    chk(!busy && !irq_req && !cfg_err, "R1 status", {busy, irq_req, cfg_err}, 0);

    // R2 flag set/clear paths
    hw_req = 4'b0010; tick(); hw_req = '0;
    chk(flags == 4'b0010, "R2 hw set", flags, 4'b0010);
    sw_write(2, 1, 0, 0, 0);
    chk(flags == 4'b0110, "R2 sw set", flags, 4'b0110);
    sw_write(2, 0, 1, 0, 0);
    chk(flags == 4'b0010, "R2 sw clr", flags, 4'b0010);
    sw_write(1, 1, 1, 0, 0);
    sw_write(3, 1, 1, 0, 0);
    chk(flags == 4'b0010, "R2 set+clr no action", flags, 4'b0010);
    sw_write(1, 0, 0, 0, 0);
    chk(flags == 4'b0010, "R2 no command", flags, 4'b0010);
    clear_all();

    // R3 software write wins over a colliding hw pulse
    hw_req = 4'b0001; sw_write(0, 0, 0, 0, 0); hw_req = '0;
    chk(flags[0] == 1'b0, "R3 hw dropped", flags, 0);
    hw_req = 4'b0100; tick(); hw_req = '0;
    hw_req = 4'b0100; sw_write(2, 0, 1, 0, 0); hw_req = '0;
    chk(flags[2] == 1'b0, "R3 clr wins", flags, 0);
    clear_all();

    // R4 disabled node latches but is not arbitrated
    sw_write(3, 0, 0, 0, 9);
    hw_req = 4'b1000; tick(); hw_req = '0;
    tick(6);
    chk(flags == 4'b1000, "R4 flag visible", flags, 4'b1000);
    chk(pend_prio == 0 && !irq_req, "R4 not arbitrated", {pend_prio, irq_req}, 0);
    clear_all();

    // R6 latency and busy length
    sw_write(0, 0, 0, 1, 3);
    tick(6);
    hw_req = 4'b0001; tick(); hw_req = '0;   // after E0
    tick(2);                                   // after E2
    chk(busy && !irq_req, "R6 busy during round", {busy, irq_req}, 2'b10);
    tick();                                    // after E3
    chk(!busy && irq_req && pend_prio == 3, "R6 result after E3", {busy, irq_req, pend_prio}, {2'b01, 8'd3});
    sw_write(0, 0, 1, 1, 3);
    sw_write(1, 0, 0, 1, 10);
    tick(6);
    hw_req = 4'b0001; tick(); hw_req = '0;   // E0
    tick();                                    // E1: round starts
    hw_req = 4'b0010; tick(); hw_req = '0;   // E2: mid-round request
    tick();                                    // E3
    chk(pend_prio == 3, "R6 round unchanged", pend_prio, 3);
    tick(3);                                   // E6
    chk(pend_prio == 10, "R6 follow-up round", pend_prio, 10);
    clear_all();

    // R5 R8 R11 sweep over priority/enable patterns
    for (int t = 0; t < 64; t++) begin
      int  pr[4];
      bit  en[4];
      int  mx;
      bit  dup;
      logic [31:0] expv;
      vec_base = 32'h4000_0001 ^ (32'(t) << 11);
      for (int i = 0; i < 4; i++) begin
        pr[i] = ((t * (i + 3) + i * 5) % 6) * 13;
        en[i] = ((t + i) % 3) != 0;
        sw_write(i, 1, 0, en[i], pr[i]);
      end
      tick(6);
      mx = 0; dup = 0;
      for (int i = 0; i < 4; i++) begin
        if (en[i] && pr[i] > mx) mx = pr[i];
        for (int j = i + 1; j < 4; j++)
          if (en[i] && en[j] && pr[i] != 0 && pr[i] == pr[j]) dup = 1;
      end
      expv = (32'(mx) << 5) | (vec_base & 32'hFFFF_FFFE);
      chk(pend_prio == 8'(mx), "R5 max priority", pend_prio, mx);
      chk(vec_addr == expv, "R8 vector", vec_addr, expv);
      chk(cfg_err == dup, "R11 dup detect", cfg_err, dup);
      chk(irq_req == (mx != 0), "R9 request", irq_req, (mx != 0));
      clear_all();
    end

    // R7 R9 R10 acceptance, level gating, return
    vec_base = 32'h8000_0401;
    sw_write(0, 1, 0, 1, 5);
    sw_write(1, 1, 0, 1, 20);
    sw_write(2, 1, 0, 1, 12);
    tick(6);
    chk(pend_prio == 20 && irq_req, "R5 winner 20", pend_prio, 20);
    chk(vec_addr == 32'h8000_0680, "R8 vector 20", vec_addr, 32'h8000_0680);
    ack = 1; tick(); ack = 0;
    chk(flags == 4'b0101, "R7 winner cleared", flags, 4'b0101);
    chk(pend_prio == 0 && !irq_req, "R7 pend zero", pend_prio, 0);
    chk(!gie && cpu_prio == 20, "R10 accept", {gie, cpu_prio}, {1'b0, 8'd20});
    ack = 1; tick(); ack = 0;
    chk(flags == 4'b0101 && cpu_prio == 20, "R7 ack ignored", {flags, cpu_prio}, {4'b0101, 8'd20});
    tick(6);
    chk(pend_prio == 12 && !irq_req, "R9 gie low masks", {pend_prio, irq_req}, {8'd12, 1'b0});
    rfe = 1; tick(); rfe = 0;
    chk(gie && !irq_req, "R10 rfe, R9 below level", {gie, irq_req}, 2'b10);
    lvl_wr = 1; lvl = 12; tick(); lvl_wr = 0;
    chk(!irq_req, "R9 equal level", irq_req, 0);
    lvl_wr = 1; lvl = 11; tick(); lvl_wr = 0;
    chk(irq_req, "R9 above level", irq_req, 1);
    ack = 1; rfe = 1; tick(); ack = 0; rfe = 0;
    chk(!gie && cpu_prio == 12 && flags == 4'b0001, "R10 ack beats rfe", {gie, cpu_prio, flags}, {1'b0, 8'd12, 4'b0001});
    tick(6);
    rfe = 1; tick(); rfe = 0;
    chk(pend_prio == 5 && !irq_req, "R9 5 below 12", {pend_prio, irq_req}, {8'd5, 1'b0});
    lvl_wr = 1; lvl = 0; tick(); lvl_wr = 0;
    chk(irq_req, "R9 level zero", irq_req, 1);
    ack = 1; tick(); ack = 0;
    tick(6);
    chk(flags == 0 && pend_prio == 0 && cpu_prio == 5, "R7 last accept", {flags, pend_prio, cpu_prio}, {4'b0, 8'd0, 8'd5});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule